// File: doc/BRIEF.md
# Multi-mode 8-bit PWM timer

An 8-bit timer/counter with one output-compare channel. The counter takes one step on each clock cycle in which the count strobe `tick` is high. A 2-bit mode field selects how it counts. The free-running mode wraps at the all-ones value. The clear-on-compare mode restarts at zero after it reaches the compare value. Fast PWM counts up and wraps. Phase-correct PWM counts up and then back down. The same field also chooses four other things: where the count turns over (TOP), whether a compare write takes effect at once or waits in a buffer until TOP, where the overflow flag sets, and how the 2-bit output-action code drives the waveform.

A sticky overflow flag and a sticky compare-match flag report events. Each flag is cleared by a one-cycle strobe. The waveform register reaches the `wave_out` pin only when the output-action code selects a real action and the output-driver enable is high. `pin_own` reports that condition to the pin multiplexer outside the block.

All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. A write is accepted on every cycle in which `cmp_we` is high.

Top module: `wavetimer8`

## Requirements
- R1: After reset, the counter and both compare registers are 0 and the count direction is up. `ovf_flag`, `cmp_flag` and the waveform register are all 0, so `wave_out` reads 0.
- R2: The counter changes only on cycles in which `tick` is high. In modes 0 (free-running) and 3 (fast PWM) it counts up by one and wraps from 0xFF to 0x00.
- R3: In mode 2 (clear-on-compare), a tick taken while the counter equals the active compare value returns the counter to 0. Otherwise the counter counts up and wraps at 0xFF. In modes 0 and 2, a write to the compare value becomes active on the next cycle.
- R4: In mode 1 (phase-correct), the counter runs 0x00 up to 0xFF, then down to 0x00, then up again. A tick taken at 0x00 while counting down sets the overflow flag. Reaching 0xFF in this mode does not set it.
- R5: In modes 0, 2 and 3, a tick taken while the counter is 0xFF sets the overflow flag.
- R6: A tick taken while the counter equals the active compare value sets the compare-match flag, in every mode.
- R7: Each flag stays set until its clear strobe (`ovf_clr`, `cmp_clr`) is high for one cycle. When a set event and the clear strobe fall in the same cycle, the flag is left set.
- R8: In modes 1 and 3, a compare write fills only the buffer. The active value loads from the buffer on the tick taken at TOP (0xFF, while counting up in mode 1). If a write falls on that same tick, the written value becomes active.
- R9: In modes 0 and 2, on a compare match the action code acts as follows: 01 toggles the waveform, 10 clears it and 11 sets it.
- R10: In mode 3, code 10 clears the waveform on a match and sets it at TOP. Code 11 sets it on a match and clears it at TOP. When the match and TOP fall on the same tick, the TOP action wins.
- R11: In mode 1, code 10 clears the waveform on a match while counting up and sets it on a match while counting down. Code 11 does the opposite.
- R12: `pin_own` is high only when `drv_en` is high and the code is not 00. In modes 1 and 3, code 01 is reserved and also leaves `pin_own` low. While `pin_own` is low, `wave_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable: one counter step per high cycle |
| mode | input | 2 | Waveform mode: 0 free-running, 1 phase-correct, 2 clear-on-compare, 3 fast PWM |
| com | input | 2 | Output-action code |
| cmp_wdata | input | 8 | Compare value to write |
| cmp_we | input | 1 | Compare write strobe |
| drv_en | input | 1 | Output-driver enable |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmp_clr | input | 1 | Write-one clear of the compare-match flag |
| wave_out | output | 1 | Waveform output, 0 when the pin is not owned |
| pin_own | output | 1 | The waveform overrides the pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
In the buffered modes, a compare write can land on the same tick as the reload at TOP. The bench provokes this by running the counter to 0xFF, clearing the match flag, and then writing 0x20 together with the TOP tick. The old buffered value 0x40 can no longer match before 0x20 comes round, so a match flag after 0x21 more ticks shows that the written value won. Two other coincidences are also forced: a flag's set event on the same tick as its clear strobe, where the flag must read set afterwards, and a fast-PWM match at 0xFF on the TOP tick, where code 10 must leave the waveform high.

// File: rtl/wavetimer8_pkg.sv
package wavetimer8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PHASE = 2'd1,
    MODE_CTC   = 2'd2,
    MODE_FAST  = 2'd3
  } wt_mode_e;

  function automatic logic wt_is_pwm(input wt_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction
endpackage

// File: rtl/wt_cmpreg.sv
module wt_cmpreg
  import wavetimer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wt_mode_e     mode,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         top_evt,
  output logic [W-1:0] act
);
  logic [W-1:0] shadow;
  logic         pwm;

  assign pwm = wt_is_pwm(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      if (we) shadow <= wdata;
      if (!pwm) begin
        if (we) act <= wdata;
      end else if (top_evt) begin
        act <= we ? wdata : shadow;
      end
    end
  end

  // R8: in buffered modes the active value moves only at TOP
  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !top_evt) |=> $stable(act));
  // R3: immediate modes take a write on the next cycle
  p_imm_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !pwm) |=> (act == $past(wdata)));
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wavetimer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  wt_mode_e     mode,
  input  logic [W-1:0] act,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         match,
  output logic         top_evt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAX  = '1;
  localparam logic [W-1:0] ZERO = '0;

  logic at_max, at_zero;
  assign at_max  = (cnt == MAX);
  assign at_zero = (cnt == ZERO);

  assign match   = tick && (cnt == act);
  assign top_evt = tick && at_max &&
                   ((mode == MODE_FAST) || ((mode == MODE_PHASE) && !down));
  assign ovf_evt = tick && ((mode == MODE_PHASE) ? (at_zero && down) : at_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      unique case (mode)
        MODE_PHASE: begin
          if (!down) begin
            if (at_max) begin
              down <= 1'b1;
              cnt  <= cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            if (at_zero) begin
              down <= 1'b0;
              cnt  <= cnt + 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        MODE_CTC: begin
          down <= 1'b0;
          cnt  <= (cnt == act) ? ZERO : cnt + 1'b1;
        end
        default: begin
          down <= 1'b0;
          cnt  <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2: no step without the strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2: wrap in the up-only modes
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max && (mode == MODE_FREE || mode == MODE_FAST)) |=> (cnt == ZERO));
  // R3: restart after a compare hit
  p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_CTC && cnt == act) |=> (cnt == ZERO));
  // R4: turn around at the peak
  p_pc_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_PHASE && !down && at_max) |=> (down && cnt == MAX - 1'b1));
endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wavetimer8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wt_mode_e mode,
  input  logic [1:0] com,
  input  logic     match,
  input  logic     top_evt,
  input  logic     down,
  output logic     wave_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_FAST: begin
          if (top_evt) begin
            if (com == 2'b10) wave_q <= 1'b1;
            else if (com == 2'b11) wave_q <= 1'b0;
          end else if (match) begin
            if (com == 2'b10) wave_q <= 1'b0;
            else if (com == 2'b11) wave_q <= 1'b1;
          end
        end
        MODE_PHASE: begin
          if (match) begin
            if (com == 2'b10) wave_q <= down;
            else if (com == 2'b11) wave_q <= !down;
          end
        end
        default: begin
          if (match) begin
            unique case (com)
              2'b01:   wave_q <= !wave_q;
              2'b10:   wave_q <= 1'b0;
              2'b11:   wave_q <= 1'b1;
              default: wave_q <= wave_q;
            endcase
          end
        end
      endcase
    end
  end

  // R10: TOP action wins over a same-tick match
  p_fast_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt && mode == MODE_FAST && com == 2'b10) |=> wave_q);
  // R9: toggle on a match in non-PWM modes
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wt_is_pwm(mode) && com == 2'b01) |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/wt_flags.sv
module wt_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~clr[i]);
    end

    // R7: sticky without a clear
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
    // R7: a set event beats a clear in the same cycle
    p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
  import wavetimer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [1:0]   com,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cmp_we,
  input  logic         drv_en,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic         wave_out,
  output logic         pin_own,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam int NFLAG = 2;

  wt_mode_e     mode_e;
  logic [W-1:0] act, cnt;
  logic         down, match, top_evt, ovf_evt, wave_q;
  logic [NFLAG-1:0] fset, fclr, fq;

  assign mode_e = wt_mode_e'(mode);

  wt_cmpreg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .we(cmp_we),
    .wdata(cmp_wdata), .top_evt(top_evt), .act(act)
  );

  wt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_e), .act(act),
    .cnt(cnt), .down(down), .match(match), .top_evt(top_evt), .ovf_evt(ovf_evt)
  );

  wt_wave u_wave (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .com(com), .match(match),
    .top_evt(top_evt), .down(down), .wave_q(wave_q)
  );

  assign fset = {ovf_evt, match};
  assign fclr = {ovf_clr, cmp_clr};

  wt_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .q(fq)
  );

  assign ovf_flag = fq[1];
  assign cmp_flag = fq[0];

  assign pin_own  = drv_en && (com != 2'b00) &&
                    !(wt_is_pwm(mode_e) && com == 2'b01);
  assign wave_out = pin_own && wave_q;

  // R12: the pin never shows a waveform it does not own
  p_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!wave_out && !pin_own));
  // R1: outputs are quiet on the first cycle after reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!ovf_flag && !cmp_flag && !wave_out));
endmodule

// File: tb/sim_wavetimer8.sv
module sim_wavetimer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] com = 2'd0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       cmp_we = 1'b0;
  logic       drv_en = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic       wave_out, pin_own, ovf_flag, cmp_flag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wavetimer8 u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .com(com),
    .cmp_wdata(cmp_wdata), .cmp_we(cmp_we), .drv_en(drv_en),
    .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .wave_out(wave_out),
    .pin_own(pin_own), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  typedef struct packed {
    logic [1:0] m;
    logic [1:0] c;
    logic [7:0] v;
    logic       d;
    logic [9:0] n;
    logic       e_ovf;
    logic       e_cmp;
    logic       e_wave;
    logic       e_pin;
  } vec_t;

  localparam int NV = 22;
  // mode, code, compare, drv_en, ticks -> ovf, cmp, wave, pin
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'b01, 8'h10, 1'b1, 10'd17,  1'b0, 1'b1, 1'b1, 1'b1}, // R9 toggle once
    '{2'd0, 2'b01, 8'h10, 1'b1, 10'd16,  1'b0, 1'b0, 1'b0, 1'b1}, // R6 not reached
    '{2'd0, 2'b10, 8'h05, 1'b1, 10'd256, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 wrap
    '{2'd0, 2'b11, 8'h05, 1'b1, 10'd6,   1'b0, 1'b1, 1'b1, 1'b1}, // R9 set
    '{2'd0, 2'b01, 8'h05, 1'b1, 10'd262, 1'b1, 1'b1, 1'b0, 1'b1}, // R9 two toggles
    '{2'd0, 2'b00, 8'h80, 1'b1, 10'd255, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 one short
    '{2'd2, 2'b01, 8'h03, 1'b1, 10'd4,   1'b0, 1'b1, 1'b1, 1'b1}, // R3
    '{2'd2, 2'b01, 8'h03, 1'b1, 10'd8,   1'b0, 1'b1, 1'b0, 1'b1}, // R3 restart
    '{2'd2, 2'b01, 8'h03, 1'b1, 10'd300, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 75 hits
    '{2'd3, 2'b10, 8'h40, 1'b1, 10'd65,  1'b0, 1'b1, 1'b0, 1'b1}, // R10
    '{2'd3, 2'b10, 8'h40, 1'b1, 10'd256, 1'b1, 1'b1, 1'b1, 1'b1}, // R10 set at TOP
    '{2'd3, 2'b10, 8'h40, 1'b1, 10'd321, 1'b1, 1'b1, 1'b0, 1'b1}, // R10 period 2
    '{2'd3, 2'b11, 8'h40, 1'b1, 10'd65,  1'b0, 1'b1, 1'b1, 1'b1}, // R10 inverted
    '{2'd3, 2'b10, 8'hFF, 1'b1, 10'd256, 1'b1, 1'b1, 1'b1, 1'b1}, // R10 TOP wins
    '{2'd3, 2'b01, 8'h40, 1'b1, 10'd65,  1'b0, 1'b1, 1'b0, 1'b0}, // R12 reserved
    '{2'd1, 2'b11, 8'h40, 1'b1, 10'd65,  1'b0, 1'b1, 1'b1, 1'b1}, // R11 up set
    '{2'd1, 2'b11, 8'h40, 1'b1, 10'd510, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 no ovf at peak
    '{2'd1, 2'b11, 8'h40, 1'b1, 10'd511, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 ovf at bottom
    '{2'd1, 2'b10, 8'h40, 1'b1, 10'd447, 1'b0, 1'b1, 1'b1, 1'b1}, // R11 down set
    '{2'd0, 2'b01, 8'h05, 1'b0, 10'd6,   1'b0, 1'b1, 1'b0, 1'b0}, // R12 no driver
    '{2'd0, 2'b00, 8'h05, 1'b1, 10'd6,   1'b0, 1'b1, 1'b0, 1'b0}, // R12 code 00
    '{2'd1, 2'b01, 8'h40, 1'b1, 10'd65,  1'b0, 1'b1, 1'b0, 1'b0}  // R12 reserved
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; cmp_we = 1'b0; ovf_clr = 1'b0; cmp_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cmp_wdata = v; cmp_we = 1'b1;
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] c, input logic [7:0] v, input logic d);
    @(negedge clk);
    mode = 2'd0;
    wr(v);
    mode = m; com = c; drv_en = d;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic pulse_cmp_clr();
    @(negedge clk); cmp_clr = 1'b1;
    @(negedge clk); cmp_clr = 1'b0;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    mode = 2'd0; com = 2'b01; drv_en = 1'b1;
    do_reset();
    @(negedge clk);
    check("R1", "ovf_flag", ovf_flag, 1'b0);
    check("R1", "cmp_flag", cmp_flag, 1'b0);
    check("R1", "wave_out", wave_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      setup(VEC[i].m, VEC[i].c, VEC[i].v, VEC[i].d);
      run(int'(VEC[i].n));
      @(negedge clk);
      check($sformatf("vec%0d", i), "ovf_flag", ovf_flag, VEC[i].e_ovf);
      check($sformatf("vec%0d", i), "cmp_flag", cmp_flag, VEC[i].e_cmp);
      check($sformatf("vec%0d", i), "wave_out", wave_out, VEC[i].e_wave);
      check($sformatf("vec%0d", i), "pin_own",  pin_own,  VEC[i].e_pin);
    end

    // R2: idle cycles without tick do not advance the count
    do_reset();
    setup(2'd0, 2'b00, 8'h80, 1'b1);
    run(255);
    repeat (20) @(negedge clk);
    check("R2", "ovf after idle", ovf_flag, 1'b0);
    run(1);
    @(negedge clk);
    check("R2", "ovf after last tick", ovf_flag, 1'b1);

    // R7: clear one flag, the other stays
    pulse_ovf_clr();
    check("R7", "ovf cleared", ovf_flag, 1'b0);
    check("R7", "cmp kept", cmp_flag, 1'b1);

    // R7: set and clear in the same cycle
    do_reset();
    setup(2'd0, 2'b00, 8'h05, 1'b1);
    run(5);
    @(negedge clk);
    tick = 1'b1; cmp_clr = 1'b1;
    @(negedge clk);
    tick = 1'b0; cmp_clr = 1'b0;
    check("R7", "set wins over clear", cmp_flag, 1'b1);
    pulse_cmp_clr();
    check("R7", "cleared", cmp_flag, 1'b0);

    // R8: buffered compare in fast PWM
    do_reset();
    setup(2'd3, 2'b00, 8'h40, 1'b1);
    wr(8'h80);
    run(65);
    @(negedge clk);
    check("R8", "old value still active", cmp_flag, 1'b1);
    pulse_cmp_clr();
    run(191);
    @(negedge clk);
    check("R8", "new value not active before TOP", cmp_flag, 1'b0);
    run(129);
    @(negedge clk);
    check("R8", "new value active after TOP", cmp_flag, 1'b1);

    // R8: write on the TOP tick
    do_reset();
    setup(2'd3, 2'b00, 8'h40, 1'b1);
    run(255);
    pulse_cmp_clr();
    @(negedge clk);
    tick = 1'b1; cmp_we = 1'b1; cmp_wdata = 8'h20;
    @(negedge clk);
    tick = 1'b0; cmp_we = 1'b0;
    check("R8", "no match on TOP tick", cmp_flag, 1'b0);
    run(33);
    @(negedge clk);
    check("R8", "same-cycle write loaded", cmp_flag, 1'b1);

    // R3: immediate write in clear-on-compare, counter past it runs to MAX
    do_reset();
    setup(2'd2, 2'b00, 8'h80, 1'b1);
    run(32);
    wr(8'h10);
    run(224);
    @(negedge clk);
    check("R3", "immediate write, old value gone", cmp_flag, 1'b0);
    check("R5", "ovf at MAX in clear-on-compare", ovf_flag, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule